// File: doc/BRIEF.md
# Host Watchdog Register Bank

This block holds the byte-wide configuration and status registers of a battery charger controller. It also holds the host watchdog that decides whether the charger follows the host's settings or falls back to safe values. A serial slave front end drives it through a plain register port: an address, write data with a write strobe, and a read strobe. The registered read data is valid one cycle after the read strobe. A one-second tick input is the timebase for the watchdog.

Every configuration field belongs to a reset class. Fields in the watchdog class go back to their power-on values when the watchdog expires. Fields in the software class keep the host's values until a software register reset is written. Examples of software-class fields are the input current code, the minimum system voltage code and the overvoltage select. A status flag reports default mode, which holds after power-on and after an expiry. Any host write returns the block to host mode. The watchdog kick bit and the register reset bit clear themselves.

The stored configuration is also driven out flat to the regulation logic, one byte per slot. Slot 5 holds the interrupt mask byte.

Top module: `chg_hostwd_regbank`

## Requirements
- R1: After reset, the registers read their defaults and `default_mode_o` is 1. The defaults are: addr 0x0 = 0x17, 0x1 = 0x2A, 0x2 = 0x91, 0x3 = 0x0D, 0x4 = 0x0B, and the mask bits of 0xA = 00. Addr 0xB reads {0, PART_ID}.
- R2: Bits [1:0] of addr 0x3 select the watchdog period. Code 00 disables the watchdog and holds its count at zero. Codes 01, 10 and 11 expire after WD_BASE, 2*WD_BASE and 4*WD_BASE ticks.
- R3: Writing addr 0x1 with bit 0 set restarts the watchdog count. Bit 0 of addr 0x1 always reads 0.
- R4: On expiry, only the watchdog-class bits return to their defaults, and `default_mode_o` goes to 1. The watchdog-class bits are: 0x0 bit 7, 0x1 bits [2:1], 0x2 all stored bits, and 0x3 bits [3:0]. Addr 0x4, 0x0 bits [4:0], 0x1 bits [5:3] and the masks keep their values.
- R5: Any write, to any address, clears `default_mode_o` on the next cycle unless an expiry happens in the same cycle. Bit 7 of addr 0x9 reads `default_mode_o`.
- R6: Writing addr 0xB with bit 7 set restores every configuration field and mask to its default and restarts the watchdog. It also raises `safety_restart_o` for the one cycle after the write. Bit 7 of 0xB reads 0.
- R7: Addr 0x8 reads `st0_i`, 0x9 reads {default mode, `st1_i`} and 0xA reads {`st2_i`, mask[1:0]}. Writes to them are ignored, except for the two mask bits [1:0] of 0xA.
- R8: The fast-charge code in bits [5:0] of addr 0x2 saturates. A written code above 50 (0x32) is stored as 50.
- R9: Read data appears on `rdata_o` in the cycle after `rd_i`. Unmapped addresses (0x5 to 0x7, 0xC to 0xF) read 0. Bits that no field uses read 0.
- R10: `cfg_o` carries slot i (addresses 0x0 to 0x4, then the mask byte) in bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second timebase pulse |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, valid the cycle after rd_i |
| st0_i | input | 8 | Live charge status byte |
| st1_i | input | 7 | Live fault flags |
| st2_i | input | 6 | Live input and regulation flags |
| default_mode_o | output | 1 | 1 while in default mode |
| safety_restart_o | output | 1 | One-cycle safety timer restart pulse |
| cfg_o | output | 48 | Stored configuration, six bytes |

## Verification
The bench builds the block with WD_BASE = 4, so the three periods expire after 4, 8 and 16 ticks. At that setting every period code, a kick just before expiry, and restarting from a disabled, zero-held count can all be run in a few hundred cycles. PART_ID keeps its default, so the identity byte is checked against the reset value.

// File: rtl/chg_regbank_pkg.sv
package chg_regbank_pkg;

  localparam int NSLOT    = 6;
  localparam int MASK_SLOT = 5;
  localparam logic [5:0] ICHG_MAX = 6'd50;

  localparam int A_STAT0 = 8;
  localparam int A_STAT1 = 9;
  localparam int A_STAT2 = 10;
  localparam int A_INFO  = 11;

  function automatic int slot_addr(input int s);
    return (s == MASK_SLOT) ? A_STAT2 : s;
  endfunction

  function automatic logic [7:0] slot_def(input int s);
    case (s)
      0: return 8'h17;
      1: return 8'h2A;
      2: return 8'h91;
      3: return 8'h0D;
      4: return 8'h0B;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] slot_wrmask(input int s);
    case (s)
      0: return 8'h9F;
      1: return 8'h3E;
      2: return 8'hBF;
      3: return 8'h0F;
      4: return 8'h0F;
      default: return 8'h03;
    endcase
  endfunction

  function automatic logic [7:0] slot_wdmask(input int s);
    case (s)
      0: return 8'h80;
      1: return 8'h06;
      2: return 8'hBF;
      3: return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [5:0] sat_ichg(input logic [5:0] c);
    return (c > ICHG_MAX) ? ICHG_MAX : c;
  endfunction

endpackage

// File: rtl/chg_cfg_slice.sv
module chg_cfg_slice #(
  parameter logic [7:0] DEF    = 8'h00,
  parameter logic [7:0] WRMASK = 8'hFF,
  parameter logic [7:0] WDMASK = 8'h00,
  parameter bit         SAT_EN = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_rst,
  input  logic       wd_rst,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] q
);
  import chg_regbank_pkg::*;

  logic [7:0] after_wd, merged, nxt;

  always_comb begin
    after_wd = (q & ~WDMASK) | (DEF & WDMASK);
    if (!wd_rst) after_wd = q;
    merged = (after_wd & ~WRMASK) | (wdata & WRMASK);
    if (SAT_EN) merged[5:0] = sat_ichg(merged[5:0]);
    nxt = wr_en ? merged : after_wd;
    if (sw_rst) nxt = DEF;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= DEF;
    else        q <= nxt;

  AST_WD_RESTORES_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_rst && !wr_en && !sw_rst) |=> ((q & WDMASK) == (DEF & WDMASK))); // R4
  AST_WD_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_rst && !wr_en && !sw_rst) |=> ((q & ~WDMASK) == ($past(q) & ~WDMASK))); // R4
  AST_SW_RESTORES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (q == DEF)); // R6
endmodule

// File: rtl/chg_wd_timer.sv
module chg_wd_timer #(
  parameter int BASE = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] period,
  input  logic       restart,
  output logic       expire
);
  localparam int CNT_W = $clog2(4 * BASE + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   lim;

  always_comb begin
    case (period)
      2'd1:    lim = (CNT_W+1)'(BASE);
      2'd2:    lim = (CNT_W+1)'(2 * BASE);
      2'd3:    lim = (CNT_W+1)'(4 * BASE);
      default: lim = '0;
    endcase
  end

  assign expire = tick && (period != 2'd0) && !restart
                  && (({1'b0, cnt} + 1'b1) >= lim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         cnt <= '0;
    else if (restart || period == 2'd0) cnt <= '0;
    else if (expire)                    cnt <= '0;
    else if (tick)                      cnt <= cnt + 1'b1;

  AST_DISABLED_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (period == 2'd0) |=> (cnt == '0)); // R2
  AST_KICK_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0)); // R3
  AST_NO_EXPIRE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (period == 2'd0) |-> !expire); // R2
endmodule

// File: rtl/chg_read_port.sv
module chg_read_port #(
  parameter int ADDR_W = 4,
  parameter logic [6:0] PART_ID = 7'h2C
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [chg_regbank_pkg::NSLOT*8-1:0] cfg,
  input  logic [7:0]                st0,
  input  logic [7:0]                st1_full,
  input  logic [5:0]                st2,
  output logic [7:0]                rdata
);
  import chg_regbank_pkg::*;

  logic [7:0] sel;

  always_comb begin
    sel = 8'h00;
    for (int s = 0; s < MASK_SLOT; s++)
      if (addr == ADDR_W'(s)) sel = cfg[s*8 +: 8];
    if (addr == ADDR_W'(A_STAT0)) sel = st0;
    if (addr == ADDR_W'(A_STAT1)) sel = st1_full;
    if (addr == ADDR_W'(A_STAT2)) sel = {st2, cfg[MASK_SLOT*8 +: 2]};
    if (addr == ADDR_W'(A_INFO))  sel = {1'b0, PART_ID};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  rdata <= 8'h00;
    else if (rd) rdata <= sel;
endmodule

// File: rtl/chg_hostwd_regbank.sv
module chg_hostwd_regbank #(
  parameter int         ADDR_W  = 4,
  parameter int         WD_BASE = 40,
  parameter logic [6:0] PART_ID = 7'h2C
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [7:0]             wdata_i,
  input  logic                   wr_i,
  input  logic                   rd_i,
  output logic [7:0]             rdata_o,
  input  logic [7:0]             st0_i,
  input  logic [6:0]             st1_i,
  input  logic [5:0]             st2_i,
  output logic                   default_mode_o,
  output logic                   safety_restart_o,
  output logic [chg_regbank_pkg::NSLOT*8-1:0] cfg_o
);
  import chg_regbank_pkg::*;

  logic kick_evt, swrst_evt, wd_expire, wd_fault, safety_q;
  logic [1:0] wd_period;
  logic [5:0] ichg_code;

  assign kick_evt  = wr_i && (addr_i == ADDR_W'(1)) && wdata_i[0];
  assign swrst_evt = wr_i && (addr_i == ADDR_W'(A_INFO)) && wdata_i[7];

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic hit;
      assign hit = wr_i && (addr_i == ADDR_W'(slot_addr(s)));
      chg_cfg_slice #(
        .DEF   (slot_def(s)),
        .WRMASK(slot_wrmask(s)),
        .WDMASK(slot_wdmask(s)),
        .SAT_EN(s == 2)
      ) u_slice (
        .clk   (clk),
        .rst_n (rst_n),
        .sw_rst(swrst_evt),
        .wd_rst(wd_expire),
        .wr_en (hit),
        .wdata (wdata_i),
        .q     (cfg_o[s*8 +: 8])
      );
    end
  endgenerate

  assign wd_period = cfg_o[3*8 +: 2];
  assign ichg_code = cfg_o[2*8 +: 6];

  chg_wd_timer #(.BASE(WD_BASE)) u_wd (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_i),
    .period (wd_period),
    .restart(kick_evt || swrst_evt),
    .expire (wd_expire)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wd_fault <= 1'b1;
      safety_q <= 1'b0;
    end else begin
      safety_q <= swrst_evt;
      if (wd_expire)  wd_fault <= 1'b1;
      else if (wr_i)  wd_fault <= 1'b0;
    end

  assign default_mode_o   = wd_fault;
  assign safety_restart_o = safety_q;

  chg_read_port #(.ADDR_W(ADDR_W), .PART_ID(PART_ID)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (rd_i),
    .addr    (addr_i),
    .cfg     (cfg_o),
    .st0     (st0_i),
    .st1_full({wd_fault, st1_i}),
    .st2     (st2_i),
    .rdata   (rdata_o)
  );

  AST_EXPIRE_SETS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> default_mode_o); // R4
  AST_WRITE_ENTERS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wd_expire) |=> !default_mode_o); // R5
  AST_SWRST_PULSES_SAFETY: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_evt |=> safety_restart_o); // R6
  AST_ICHG_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    ichg_code <= ICHG_MAX); // R8
  AST_KICK_BIT_UNSTORED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[8] == 1'b0); // R3
endmodule

// File: tb/chg_hostwd_regbank_bench.sv
module chg_hostwd_regbank_bench;
  localparam int ADDR_W = 4;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic [7:0] st0_i = 8'hC3;
  logic [6:0] st1_i = 7'h15;
  logic [5:0] st2_i = 6'h2A;
  logic default_mode_o, safety_restart_o;
  logic [47:0] cfg_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic rd_q = 1'b0;
  sb_item_t sb[$];

  always #4 clk = ~clk;

  chg_hostwd_regbank #(.ADDR_W(ADDR_W), .WD_BASE(4)) u_chg_hostwd_regbank (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o),
    .st0_i(st0_i), .st1_i(st1_i), .st2_i(st2_i),
    .default_mode_o(default_mode_o), .safety_restart_o(safety_restart_o),
    .cfg_o(cfg_o)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when the registered result is valid
  always @(posedge clk) rd_q <= rd_i;
  always @(negedge clk) begin
    if (rd_q) begin
      if (sb.size() == 0) chk("R9 unexpected read", 1, 0);
      else begin
        sb_item_t it;
        it = sb.pop_front();
        chk(it.tag, {56'h0, rdata_o}, {56'h0, it.exp});
      end
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    addr_i = ADDR_W'(a); wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input int a, input logic [7:0] exp, input string tag);
    sb_item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    addr_i = ADDR_W'(a); rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_i = 1'b1;
      @(negedge clk);
    end
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 default mode after reset", default_mode_o, 1);
    chk("R10 cfg_o after reset", cfg_o, 48'h000B0D912A17);
    rd(0, 8'h17, "R1 inlim default");
    rd(1, 8'h2A, "R1 ctrl default");
    rd(2, 8'h91, "R1 ichg default");
    rd(3, 8'h0D, "R1 timer default");
    rd(4, 8'h0B, "R1 prot default");
    rd(10, 8'hA8, "R1 mask default");
    rd(11, 8'h2C, "R1 info id");
    rd(9, 8'h95, "R5 stat1 shows default mode");
    // R5 any write enters host mode
    wr(0, 8'h85);
    chk("R5 host mode after write", default_mode_o, 0);
    rd(9, 8'h15, "R5 stat1 host mode");
    rd(0, 8'h85, "R1 inlim written");
    // R8 saturation
    wr(2, 8'h3F); rd(2, 8'h32, "R8 ichg 63 clamps");
    wr(2, 8'h33); rd(2, 8'h32, "R8 ichg 51 clamps");
    wr(2, 8'h31); rd(2, 8'h31, "R8 ichg 49 kept");
    wr(2, 8'h32); rd(2, 8'h32, "R8 ichg 50 kept");
    // R3 kick bit reads 0
    wr(1, 8'h3D); rd(1, 8'h3C, "R3 kick bit reads zero");
    wr(4, 8'hFE); rd(4, 8'h0E, "R9 unused prot bits read zero");
    // R7 status
    wr(10, 8'hFF); rd(10, 8'hAB, "R7 mask bits writable");
    wr(8, 8'h55); rd(8, 8'hC3, "R7 stat0 write ignored");
    wr(11, 8'h7F); rd(11, 8'h2C, "R7 info write ignored");
    // R9 unmapped
    rd(5, 8'h00, "R9 unmapped 5");
    rd(14, 8'h00, "R9 unmapped 14");
    // R4 expiry with period 01
    wr(1, 8'h3D);
    ticks(3);
    chk("R2 no expiry before 4 ticks", default_mode_o, 0);
    ticks(1);
    chk("R4 expiry sets default mode", default_mode_o, 1);
    rd(0, 8'h05, "R4 inlim code kept hiz restored");
    rd(1, 8'h3A, "R4 ctrl sysmin kept enables restored");
    rd(2, 8'h91, "R4 ichg restored");
    rd(4, 8'h0E, "R4 prot kept");
    rd(10, 8'hAB, "R4 masks kept");
    rd(9, 8'h95, "R4 stat1 default mode");
    // R3 kick restarts count
    wr(1, 8'h03);
    ticks(3);
    wr(1, 8'h03);
    ticks(3);
    chk("R3 kick postpones expiry", default_mode_o, 0);
    ticks(1);
    chk("R3 expiry 4 ticks after kick", default_mode_o, 1);
    // R2 period 10
    wr(3, 8'h0E); wr(1, 8'h03);
    ticks(7);
    chk("R2 period 10 not yet", default_mode_o, 0);
    ticks(1);
    chk("R2 period 10 expires at 8", default_mode_o, 1);
    rd(3, 8'h0D, "R4 period restored");
    // R2 period 11
    wr(3, 8'h0F); wr(1, 8'h03);
    ticks(15);
    chk("R2 period 11 not yet", default_mode_o, 0);
    ticks(1);
    chk("R2 period 11 expires at 16", default_mode_o, 1);
    // R2 disabled holds zero
    wr(3, 8'h0C); wr(1, 8'h03);
    ticks(40);
    chk("R2 disabled never expires", default_mode_o, 0);
    rd(3, 8'h0C, "R2 disabled period kept");
    wr(3, 8'h0D);
    ticks(3);
    chk("R2 count held zero while disabled", default_mode_o, 0);
    ticks(1);
    chk("R2 full period after enable", default_mode_o, 1);
    // R6 software reset
    wr(0, 8'h9F); wr(4, 8'h03); wr(10, 8'h03); wr(2, 8'h05);
    chk("R6 no safety pulse before reset", safety_restart_o, 0);
    wr(11, 8'h80);
    chk("R6 safety pulse", safety_restart_o, 1);
    chk("R5 swreset write enters host mode", default_mode_o, 0);
    @(negedge clk);
    chk("R6 safety pulse one cycle", safety_restart_o, 0);
    chk("R10 cfg_o after swreset", cfg_o, 48'h000B0D912A17);
    rd(0, 8'h17, "R6 inlim default");
    rd(4, 8'h0B, "R6 prot default");
    rd(10, 8'hA8, "R6 masks default");
    rd(11, 8'h2C, "R6 reset bit reads zero");
    ticks(3);
    chk("R6 watchdog restarted by swreset", default_mode_o, 0);
    repeat (3) @(negedge clk);
    chk("R9 scoreboard drained", sb.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule